// File: doc/BRIEF.md
# Slot Reel Animation Address Generator

This block animates three vertical slot-machine reels and turns the raster position of the display into sprite ROM addresses. Each reel is a strip of seven symbols, each shown as a 128×128 tile, so a reel is 896 pixels tall. A per-reel vertical offset sets which part of the strip is visible. The window shows three tile rows, and the middle row is the payline.

A one-cycle start pulse latches three target indices and starts a spin. After that, every frame strobe moves the reels. All reels first run fast. Then they drop out in order, reel 1 first, into a slow approach. Each slow reel is clamped so that it lands exactly on an offset that puts its target symbol in the payline.

For each pixel, the block finds the reel, the symbol tile and the position inside the 2×-scaled 64×64 sprite. It issues the sprite number and the word address, and it later picks one 4-bit pixel from the 16-bit word the ROM returns.

Top module: `slot_reel_gen`

## Requirements
- R1: After reset all three offsets are 0 and the block is idle. At the top-left pixel of the payline (row 1 of the window), the reels show sprites 1, 0 and 5 at word address 0.
- R2: Each reel maps a tile index to a sprite through its own order:
  - reel 1: 0,1,2,3,4,5,6
  - reel 2: 3,0,6,2,4,1,5
  - reel 3: 2,5,0,3,6,1,4
  - The tile index is pos/128, where pos = (vcount − REEL_Y0 + offset) mod 896.
- R3: The sprite coordinates are sy = (pos mod 128)/2 and sx = (hcount − reel_left)/2. The word address is sy×16 + sx/4. Bits 9:8 of the word address select the bank and bits 7:0 select the word.
- R4: Reels sit side by side, 128 pixels wide, starting at REEL_X0. Rows span 384 lines from REEL_Y0. Any pixel outside that area raises sprite_none and yields pixel_valid low.
- R5: sprite_num, sprite_none and rom_addr appear one clock after the coordinates. pixel and pixel_valid appear ROM_LAT clocks after that. pixel is nibble sx mod 4 of rom_word, where nibble k occupies bits 4k+3:4k.
- R6: A start pulse taken while idle latches the targets and loads spin counts of 3, 2 and 2. The phases then run in order: idle, all spinning, reel 1 stopping, reel 2 stopping, reel 3 stopping, idle.
- R7: A reel that is not yet slowing advances 24 pixels per frame strobe, modulo 896.
- R8: In the all-spinning phase only reel 1 counts its wraps; in the reel 1 stopping phase only reel 2 counts; in the reel 2 stopping phase only reel 3 counts. When the counting reel's count reaches zero, the next phase begins, and from then on that reel moves 12 pixels per frame.
- R9: A slowing reel heads for offset (t×128 + 896 − 128) mod 896, where t is its target index and any target above 6 is taken as 6. If the remaining distance is 12 or less, the offset becomes exactly that value and the reel is stopped. After landing, the payline shows that reel's sprite for index t at word address 0.
- R10: A stopped reel keeps its offset. The block returns to idle once all three reels have landed, and the offsets then stay fixed, even across frame strobes, until the next start.
- R11: Offsets change only on a clock with frame_tick high.
- R12: A start pulse received while a spin is in progress is ignored, both its targets and its restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hcount | input | 10 | Horizontal raster position |
| vcount | input | 10 | Vertical raster position |
| frame_tick | input | 1 | One-cycle frame-complete strobe |
| start_spin | input | 1 | One-cycle spin command |
| tgt_r1 | input | 4 | Target index for reel 1 |
| tgt_r2 | input | 4 | Target index for reel 2 |
| tgt_r3 | input | 4 | Target index for reel 3 |
| rom_word | input | 16 | Word returned by the sprite ROM |
| sprite_num | output | 3 | Sprite to read |
| sprite_none | output | 1 | Pixel lies outside every reel |
| rom_addr | output | 10 | Word address inside the sprite |
| pixel | output | 4 | Selected pixel nibble |
| pixel_valid | output | 1 | pixel belongs to a reel |

## Verification
The bench builds the block with its default geometry: reels start at column 64 and line 48, and the ROM latency is two. This lets one fixed probe pixel per reel read back the full state of that reel's offset through sprite_num and rom_addr. Because the frame strobe is a port, the bench fires it on back-to-back frames. A whole spin, including each wrap count, each slow approach and each clamped landing, therefore fits in a few thousand clocks and is compared frame by frame against a model. A target above 6 and a start pulse in the middle of a spin are both exercised within the same run.

// File: rtl/slot_reel_pkg.sv
package slot_reel_pkg;
  localparam int NUM_REELS = 3;
  localparam int NSYM      = 7;
  localparam int ROW_H     = 128;
  localparam int TOTAL_H   = NSYM * ROW_H;
  localparam int OFF_W     = $clog2(TOTAL_H);
  localparam int SPR_DIM   = ROW_H / 2;
  localparam int ADDR_W    = $clog2(SPR_DIM * SPR_DIM / 4);
  localparam int FAST_STEP = 24;
  localparam int SLOW_STEP = 12;
  localparam int CENTER    = ROW_H;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0, ST_SPIN = 3'd1, ST_STOP1 = 3'd2, ST_STOP2 = 3'd3, ST_STOP3 = 3'd4
  } reel_st_e;

  function automatic logic [2:0] sym_of(input int reel, input logic [2:0] idx);
    case (reel)
      0: return (idx > 3'd6) ? 3'd6 : idx;
      1: case (idx)
           3'd0: return 3'd3; 3'd1: return 3'd0; 3'd2: return 3'd6; 3'd3: return 3'd2;
           3'd4: return 3'd4; 3'd5: return 3'd1; default: return 3'd5;
         endcase
      default: case (idx)
           3'd0: return 3'd2; 3'd1: return 3'd5; 3'd2: return 3'd0; 3'd3: return 3'd3;
           3'd4: return 3'd6; 3'd5: return 3'd1; default: return 3'd4;
         endcase
    endcase
  endfunction

  function automatic logic [OFF_W-1:0] landing(input logic [3:0] t);
    int tt;
    tt = (t > 4'd6) ? 6 : int'(t);
    return OFF_W'((tt * ROW_H + TOTAL_H - CENTER) % TOTAL_H);
  endfunction

  // {wrapped, next offset}
  function automatic logic [OFF_W:0] fast_step(input logic [OFF_W-1:0] off);
    int n;
    n = int'(off) + FAST_STEP;
    if (n >= TOTAL_H) return {1'b1, OFF_W'(n - TOTAL_H)};
    return {1'b0, OFF_W'(n)};
  endfunction

  // {landed, next offset}
  function automatic logic [OFF_W:0] slow_step(input logic [OFF_W-1:0] off,
                                               input logic [OFF_W-1:0] tgt);
    int d, n;
    d = (int'(tgt) - int'(off) + TOTAL_H) % TOTAL_H;
    if (d <= SLOW_STEP) return {1'b1, tgt};
    n = (int'(off) + SLOW_STEP) % TOTAL_H;
    return {1'b0, OFF_W'(n)};
  endfunction
endpackage

// File: rtl/slot_reel_pipe.sv
module slot_reel_pipe #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [DEPTH-1:0][WIDTH-1:0] sr;
      always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else begin
          sr[0] <= d;
          for (int k = 1; k < DEPTH; k++) sr[k] <= sr[k-1];
        end
      end
      assign q = sr[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/slot_reel_motion.sv
module slot_reel_motion
  import slot_reel_pkg::*;
#(
  parameter int SPINS1 = 3,
  parameter int SPINS2 = 2,
  parameter int SPINS3 = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_tick,
  input  logic                          start_spin,
  input  logic [3:0]                    tgt_r1,
  input  logic [3:0]                    tgt_r2,
  input  logic [3:0]                    tgt_r3,
  output logic [NUM_REELS-1:0][OFF_W-1:0] off_q,
  output logic [NUM_REELS-1:0][OFF_W-1:0] tgt_q,
  output reel_st_e                      state_q,
  output logic [NUM_REELS-1:0]          wrap_ev,
  output logic [NUM_REELS-1:0]          land_ev
);
  localparam int SPIN_MAX = (SPINS1 > SPINS2) ? ((SPINS1 > SPINS3) ? SPINS1 : SPINS3)
                                              : ((SPINS2 > SPINS3) ? SPINS2 : SPINS3);
  localparam int CNT_W = $clog2(SPIN_MAX + 1);

  logic [NUM_REELS-1:0][CNT_W-1:0] cnt_q, cnt_d;
  logic [NUM_REELS-1:0][OFF_W-1:0] off_d, tgt_d;
  logic [NUM_REELS-1:0]            landed_q, landed_d;
  reel_st_e                        state_d;
  logic                            advance;
  int                              rank;

  always_comb begin
    off_d    = off_q;
    tgt_d    = tgt_q;
    cnt_d    = cnt_q;
    landed_d = landed_q;
    state_d  = state_q;
    wrap_ev  = '0;
    land_ev  = '0;
    advance  = 1'b0;
    rank     = int'(state_q);
    if (state_q == ST_IDLE) begin
      if (start_spin) begin
        tgt_d[0] = landing(tgt_r1);
        tgt_d[1] = landing(tgt_r2);
        tgt_d[2] = landing(tgt_r3);
        cnt_d[0] = CNT_W'(SPINS1);
        cnt_d[1] = CNT_W'(SPINS2);
        cnt_d[2] = CNT_W'(SPINS3);
        landed_d = '0;
        state_d  = ST_SPIN;
      end
    end else if (frame_tick) begin
      for (int i = 0; i < NUM_REELS; i++) begin
        if (!landed_q[i]) begin
          if (rank >= i + 2) begin
            {land_ev[i], off_d[i]} = slow_step(off_q[i], tgt_q[i]);
            landed_d[i] = land_ev[i];
          end else begin
            {wrap_ev[i], off_d[i]} = fast_step(off_q[i]);
            if (rank == i + 1 && wrap_ev[i]) begin
              cnt_d[i] = cnt_q[i] - 1'b1;
              if (cnt_q[i] == CNT_W'(1)) advance = 1'b1;
            end
          end
        end
      end
      if (state_q == ST_STOP3 && (&landed_d)) state_d = ST_IDLE;
      else if (advance) state_d = reel_st_e'(state_q + 3'd1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q    <= '0;
      tgt_q    <= '0;
      cnt_q    <= '0;
      landed_q <= '1;
      state_q  <= ST_IDLE;
    end else begin
      off_q    <= off_d;
      tgt_q    <= tgt_d;
      cnt_q    <= cnt_d;
      landed_q <= landed_d;
      state_q  <= state_d;
    end
  end
endmodule

// File: rtl/slot_reel_raster.sv
module slot_reel_raster
  import slot_reel_pkg::*;
#(
  parameter int HW      = 10,
  parameter int VW      = 10,
  parameter int REEL_X0 = 64,
  parameter int REEL_Y0 = 48
) (
  input  logic [HW-1:0]                   hcount,
  input  logic [VW-1:0]                   vcount,
  input  logic [NUM_REELS-1:0][OFF_W-1:0] off,
  output logic                            none,
  output logic [2:0]                      sprite,
  output logic [ADDR_W-1:0]               addr,
  output logic [1:0]                      nib
);
  localparam int X_END = REEL_X0 + NUM_REELS * ROW_H;
  localparam int Y_END = REEL_Y0 + 3 * ROW_H;

  int hrel, vrel, reel, pos, sy, sx;

  always_comb begin
    hrel   = int'(hcount) - REEL_X0;
    vrel   = int'(vcount) - REEL_Y0;
    reel   = 0;
    pos    = 0;
    sy     = 0;
    sx     = 0;
    none   = 1'b1;
    sprite = '0;
    addr   = '0;
    nib    = '0;
    if (int'(hcount) >= REEL_X0 && int'(hcount) < X_END &&
        int'(vcount) >= REEL_Y0 && int'(vcount) < Y_END) begin
      reel = hrel / ROW_H;
      pos  = vrel + int'(off[2'(reel)]);
      if (pos >= TOTAL_H) pos = pos - TOTAL_H;
      sy     = (pos % ROW_H) / 2;
      sx     = (hrel % ROW_H) / 2;
      none   = 1'b0;
      sprite = sym_of(reel, 3'(pos / ROW_H));
      addr   = ADDR_W'(sy * (SPR_DIM / 4) + sx / 4);
      nib    = 2'(sx);
    end
  end
endmodule

// File: rtl/slot_reel_gen.sv
module slot_reel_gen
  import slot_reel_pkg::*;
#(
  parameter int HW      = 10,
  parameter int VW      = 10,
  parameter int REEL_X0 = 64,
  parameter int REEL_Y0 = 48,
  parameter int ROM_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hcount,
  input  logic [VW-1:0] vcount,
  input  logic          frame_tick,
  input  logic          start_spin,
  input  logic [3:0]    tgt_r1,
  input  logic [3:0]    tgt_r2,
  input  logic [3:0]    tgt_r3,
  input  logic [15:0]   rom_word,
  output logic [2:0]    sprite_num,
  output logic          sprite_none,
  output logic [9:0]    rom_addr,
  output logic [3:0]    pixel,
  output logic          pixel_valid
);
  localparam int S1_W = 1 + 3 + ADDR_W + 2;

  logic [NUM_REELS-1:0][OFF_W-1:0] off_w, tgt_w;
  reel_st_e                        st_w;
  logic [NUM_REELS-1:0]            wrap_w, land_w;
  logic                            none_c;
  logic [2:0]                      sprite_c;
  logic [ADDR_W-1:0]               addr_c;
  logic [1:0]                      nib_c, nib_s1, nib_px;
  logic [S1_W-1:0]                 s1_q;
  logic                            valid_px;
  logic [2:0]                      late_q;

  slot_reel_motion u_motion (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .start_spin(start_spin),
    .tgt_r1(tgt_r1), .tgt_r2(tgt_r2), .tgt_r3(tgt_r3),
    .off_q(off_w), .tgt_q(tgt_w), .state_q(st_w), .wrap_ev(wrap_w), .land_ev(land_w)
  );

  slot_reel_raster #(.HW(HW), .VW(VW), .REEL_X0(REEL_X0), .REEL_Y0(REEL_Y0)) u_raster (
    .hcount(hcount), .vcount(vcount), .off(off_w),
    .none(none_c), .sprite(sprite_c), .addr(addr_c), .nib(nib_c)
  );

  slot_reel_pipe #(.WIDTH(S1_W), .DEPTH(1)) u_addr_stage (
    .clk(clk), .rst_n(rst_n), .d({none_c, sprite_c, addr_c, nib_c}), .q(s1_q)
  );

  assign sprite_none = s1_q[S1_W-1];
  assign sprite_num  = s1_q[S1_W-2 -: 3];
  assign rom_addr    = s1_q[2 +: ADDR_W];
  assign nib_s1      = s1_q[1:0];

  slot_reel_pipe #(.WIDTH(3), .DEPTH(ROM_LAT)) u_lat_stage (
    .clk(clk), .rst_n(rst_n), .d({~sprite_none, nib_s1}), .q(late_q)
  );

  assign valid_px    = late_q[2];
  assign nib_px      = late_q[1:0];
  assign pixel       = rom_word[{nib_px, 2'b00} +: 4];
  assign pixel_valid = valid_px;
endmodule

// File: rtl/slot_reel_chk.sv
module slot_reel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_tick,
  input logic        start_spin,
  input logic [2:0]  st,
  input logic [29:0] off,
  input logic [29:0] tgt,
  input logic [2:0]  land_ev
);
  AST_OFF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    off[9:0] < 10'd896 && off[19:10] < 10'd896 && off[29:20] < 10'd896); // R7
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(off)); // R11
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd0 |=> $stable(off)); // R10
  AST_LAND_R1: assert property (@(posedge clk) disable iff (!rst_n)
    land_ev[0] |=> off[9:0] == tgt[9:0]); // R9
  AST_LAND_R2: assert property (@(posedge clk) disable iff (!rst_n)
    land_ev[1] |=> off[19:10] == tgt[19:10]); // R9
  AST_LAND_R3: assert property (@(posedge clk) disable iff (!rst_n)
    land_ev[2] |=> off[29:20] == tgt[29:20]); // R9
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    st != 3'd0 && start_spin |=> $stable(tgt)); // R12
  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd2 |=> st == 3'd2 || st == 3'd3); // R6
endmodule

bind slot_reel_gen slot_reel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .start_spin(start_spin),
  .st(st_w), .off(off_w), .tgt(tgt_w), .land_ev(land_w)
);

// File: tb/slot_reel_gen_tb.sv
module slot_reel_gen_tb;
  localparam int X0 = 64, Y0 = 48, LAT = 2;

  logic clk = 0, rst_n = 0, frame_tick = 0, start_spin = 0;
  logic [9:0] hcount = 0, vcount = 0;
  logic [3:0] tgt_r1 = 0, tgt_r2 = 0, tgt_r3 = 0;
  logic [15:0] rom_word;
  logic [2:0] sprite_num;
  logic sprite_none, pixel_valid;
  logic [9:0] rom_addr;
  logic [3:0] pixel;
  logic [15:0] rom_pipe [LAT];

  int total = 0, bad = 0;
  bit done = 0;
  int m_off[3], m_tgt[3], m_cnt[3], m_land[3], m_st;
  int tbl[3][7] = '{'{0,1,2,3,4,5,6}, '{3,0,6,2,4,1,5}, '{2,5,0,3,6,1,4}};

  always #10 clk = ~clk;

  slot_reel_gen u_dut (
    .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount),
    .frame_tick(frame_tick), .start_spin(start_spin),
    .tgt_r1(tgt_r1), .tgt_r2(tgt_r2), .tgt_r3(tgt_r3), .rom_word(rom_word),
    .sprite_num(sprite_num), .sprite_none(sprite_none), .rom_addr(rom_addr),
    .pixel(pixel), .pixel_valid(pixel_valid)
  );

  function automatic int romf(int spr, int adr);
    return (spr * 4099 + adr * 37 + 16'h5A5A) & 16'hFFFF;
  endfunction

  always @(posedge clk) begin
    rom_pipe[0] <= 16'(romf(int'(sprite_num), int'(rom_addr)));
    for (int k = 1; k < LAT; k++) rom_pipe[k] <= rom_pipe[k-1];
  end
  assign rom_word = rom_pipe[LAT-1];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // probe top-left of payline for each reel; compare with model offsets
  task automatic probe_all(input string tag);
    for (int r = 0; r < 3; r++) begin
      int pos;
      @(negedge clk);
      hcount = 10'(X0 + r * 128);
      vcount = 10'(Y0 + 128);
      @(posedge clk); #1;
      pos = (128 + m_off[r]) % 896;
      chk(int'(sprite_num) == tbl[r][pos / 128], {tag, " sprite"}, sprite_num, tbl[r][pos / 128]);
      chk(int'(rom_addr) == ((pos % 128) / 2) * 16, {tag, " addr"}, rom_addr, ((pos % 128) / 2) * 16);
    end
  endtask

  function automatic int land_of(int t);
    int tt = (t > 6) ? 6 : t;
    return (tt * 128 + 896 - 128) % 896;
  endfunction

  task automatic model_frame();
    int nst = m_st;
    if (m_st == 0) return;
    for (int i = 0; i < 3; i++) begin
      if (m_land[i] == 0) begin
        if (m_st >= i + 2) begin
          int d = (m_tgt[i] - m_off[i] + 896) % 896;
          if (d <= 12) begin m_off[i] = m_tgt[i]; m_land[i] = 1; end
          else m_off[i] = (m_off[i] + 12) % 896;
        end else begin
          int n = m_off[i] + 24;
          m_off[i] = n % 896;
          if (m_st == i + 1 && n >= 896) begin
            m_cnt[i]--;
            if (m_cnt[i] == 0) nst = m_st + 1;
          end
        end
      end
    end
    if (m_st == 4 && m_land[0] == 1 && m_land[1] == 1 && m_land[2] == 1) nst = 0;
    m_st = nst;
  endtask

  task automatic frame();
    @(negedge clk); frame_tick = 1;
    @(negedge clk); frame_tick = 0;
    model_frame();
  endtask

  task automatic start(input int a, input int b, input int c);
    @(negedge clk);
    tgt_r1 = 4'(a); tgt_r2 = 4'(b); tgt_r3 = 4'(c); start_spin = 1;
    if (m_st == 0) begin
      m_tgt[0] = land_of(a); m_tgt[1] = land_of(b); m_tgt[2] = land_of(c);
      m_cnt = '{3, 2, 2}; m_land = '{0, 0, 0}; m_st = 1;
    end
    @(negedge clk); start_spin = 0;
  endtask

  task automatic t_reset();
    probe_all("R1 reset");
  endtask

  task automatic t_outside();
    @(negedge clk); hcount = 10'(X0 - 1); vcount = 10'(Y0 + 5);
    @(posedge clk); #1;
    chk(sprite_none == 1, "R4 left of reels none", sprite_none, 1);
    repeat (LAT) @(posedge clk); #1;
    chk(pixel_valid == 0, "R4 left of reels valid", pixel_valid, 0);
    @(negedge clk); hcount = 10'(X0 + 384); vcount = 10'(Y0 + 5);
    @(posedge clk); #1;
    chk(sprite_none == 1, "R4 right edge none", sprite_none, 1);
    @(negedge clk); hcount = 10'(X0 + 10); vcount = 10'(Y0 + 384);
    @(posedge clk); #1;
    chk(sprite_none == 1, "R4 below reels none", sprite_none, 1);
  endtask

  task automatic t_pixel(input int r, input int dx, input int dy);
    int pos, sy, sx, spr, adr, w;
    @(negedge clk); hcount = 10'(X0 + r * 128 + dx); vcount = 10'(Y0 + dy);
    pos = (dy + m_off[r]) % 896;
    sy = (pos % 128) / 2; sx = dx / 2;
    spr = tbl[r][pos / 128]; adr = sy * 16 + sx / 4;
    @(posedge clk); #1;
    chk(sprite_none == 0, "R4 inside reel", sprite_none, 0);
    chk(int'(sprite_num) == spr, "R2 sprite map", sprite_num, spr);
    chk(int'(rom_addr) == adr, "R3 word address", rom_addr, adr);
    repeat (LAT) @(posedge clk); #1;
    w = romf(spr, adr);
    chk(pixel_valid == 1, "R5 pixel valid", pixel_valid, 1);
    chk(int'(pixel) == ((w >> (4 * (sx % 4))) & 15), "R5 nibble select", pixel, (w >> (4 * (sx % 4))) & 15);
  endtask

  task automatic t_idle_ticks();
    frame(); frame();
    probe_all("R10 idle ticks");
  endtask

  task automatic t_spin(input int a, input int b, input int c, input bit poke);
    int n = 0;
    int ts[3];
    ts[0] = (a > 6) ? 6 : a; ts[1] = (b > 6) ? 6 : b; ts[2] = (c > 6) ? 6 : c;
    start(a, b, c);
    probe_all("R11 start no move");
    while (m_st != 0 && n < 2000) begin
      frame();
      n++;
      if (poke && n == 20) begin
        start((a + 3) % 7, (b + 1) % 7, (c + 5) % 7); // R12 must be ignored
      end
      probe_all("R7 R8 frame step");
    end
    chk(m_st == 0, "R6 reaches idle", m_st, 0);
    for (int r = 0; r < 3; r++) begin
      @(negedge clk); hcount = 10'(X0 + r * 128); vcount = 10'(Y0 + 128);
      @(posedge clk); #1;
      chk(int'(sprite_num) == tbl[r][ts[r]], "R9 payline symbol", sprite_num, tbl[r][ts[r]]);
      chk(rom_addr == 0, "R9 payline aligned", rom_addr, 0);
    end
    frame(); frame();
    probe_all("R10 hold after stop");
  endtask

  initial begin
    m_off = '{0, 0, 0}; m_tgt = '{0, 0, 0}; m_cnt = '{0, 0, 0}; m_land = '{1, 1, 1}; m_st = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_outside();
    t_pixel(1, 37, 10);
    t_pixel(2, 127, 383);
    t_pixel(0, 6, 200);
    t_idle_ticks();
    t_spin(4, 2, 6, 1'b1);
    t_pixel(2, 70, 250);
    t_spin(9, 0, 13, 1'b0);
    t_pixel(0, 99, 131);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule